// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block supplies word addresses to a processor's data memory port. It holds two banks of pointer register sets, a primary and a secondary. Each set has an index, a modifier, a length and a base. When an access is requested, the block presents the selected set's current index as the address. In the same clock edge it advances that index by a chosen modifier.

The advance stays inside a circular window `[base, base+length)`. The window may start at any word and may have any length, so neither alignment nor a power-of-two size is needed. Software never has to test for the end of a buffer. A length of zero turns the wrap off, and the pointer then simply moves linearly.

A bit-reversed output mode serves FFT reordering. In this mode the low N bits of the emitted address are mirrored, while the pointer update itself is unchanged. A write port loads any register of the bank that is currently selected. A level on `bank_sel` chooses which bank both accesses and writes use.

Top module: `cbuf_agen`

## Requirements
- R1: While `rst` is high at a clock edge, all pointer registers of both banks are cleared to zero, and the outputs read `addr_valid`=0 and `addr`=0 after that edge.
- R2: An access sampled at an edge (`acc_valid`=1) presents the selected set's index on `addr`, with `addr_valid`=1, right after that same edge. `addr_valid` is 0 after any edge without an access.
- R3: On an access the index becomes `index + modifier`, with the modifier taken as two's complement. If the length is nonzero and the sum is at or above `base + length`, the length is subtracted.
- R4: If the length is nonzero and the sum is below `base`, the length is added. A negative modifier therefore wraps from the bottom of the window back to its top.
- R5: With a length of zero, the index update is a plain addition modulo 2^32, with no wrap.
- R6: With `brev_en`=1, bits `[N-1:0]` of the emitted address are the index's bits `[N-1:0]` in reverse order, where N=`brev_n` (0..32). Higher bits are copied unchanged. The stored index is updated exactly as in R3 to R5.
- R7: `bank_sel`=0 selects the primary bank and 1 the secondary, for both writes and accesses. Changing `bank_sel` alters no register contents.
- R8: A write (`wr_en`=1) stores `wr_data` into register slot `wr_slot` of the selected bank. The class is chosen by `wr_class`: 0 index, 1 modifier, 2 length, 3 base. The new value is used by an access from the next cycle on.
- R9: If a write of class index and an access target the same set in one cycle, the access emits the old index and the written value is what remains stored.
- R10: `addr` holds its previous value across cycles without an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Bank choice: 0 primary, 1 secondary |
| wr_en | input | 1 | Register write strobe |
| wr_class | input | 2 | Register class: 0 index, 1 modifier, 2 length, 3 base |
| wr_slot | input | SW (4) | Register set number for the write |
| wr_data | input | W (32) | Write value |
| acc_valid | input | 1 | Access request |
| acc_ptr | input | SW (4) | Set providing index, base and length |
| acc_mod | input | SW (4) | Set whose modifier is applied |
| brev_en | input | 1 | Bit-reversed output for this access |
| brev_n | input | NBW (6) | Number of low bits to mirror, 0..W |
| addr_valid | output | 1 | Address presented this cycle |
| addr | output | W (32) | Registered word address |

## Verification
The write port and the post-modify update can land on the same index register in one cycle. The bench provokes this both in a directed step and many times in a random phase, where writes and accesses are issued independently. The outcome is judged through the ports: the address emitted in that cycle must be the old index, and the next access to the set must start from the written value, which the reference model predicts cycle by cycle. Bank switching mid-sequence is checked the same way, by returning to a bank and confirming its pointer resumed untouched.

// File: rtl/cbuf_agen_pkg.sv
package cbuf_agen_pkg;
  typedef enum logic [1:0] {
    CLS_INDEX  = 2'd0,
    CLS_MODIFY = 2'd1,
    CLS_LENGTH = 2'd2,
    CLS_BASE   = 2'd3
  } reg_class_e;
endpackage

// File: rtl/cbuf_regbank.sv
module cbuf_regbank
  import cbuf_agen_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int DAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  reg_class_e     wr_class,
  input  logic [DAW-1:0] wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic           upd_en,
  input  logic [DAW-1:0] upd_addr,
  input  logic [W-1:0]   upd_data,
  input  logic [DAW-1:0] rd_ptr_addr,
  input  logic [DAW-1:0] rd_mod_addr,
  output logic [W-1:0]   rd_idx,
  output logic [W-1:0]   rd_base,
  output logic [W-1:0]   rd_len,
  output logic [W-1:0]   rd_mod
);
  logic [W-1:0] idx_mem  [DEPTH];
  logic [W-1:0] mod_mem  [DEPTH];
  logic [W-1:0] len_mem  [DEPTH];
  logic [W-1:0] base_mem [DEPTH];

  // Index store: the register write has priority over the post-modify update
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) idx_mem[k] <= '0;
    end else if (wr_en && wr_class == CLS_INDEX) begin
      idx_mem[wr_addr] <= wr_data;
      if (upd_en && upd_addr != wr_addr) idx_mem[upd_addr] <= upd_data;
    end else if (upd_en) begin
      idx_mem[upd_addr] <= upd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) begin
        mod_mem[k]  <= '0;
        len_mem[k]  <= '0;
        base_mem[k] <= '0;
      end
    end else if (wr_en) begin
      case (wr_class)
        CLS_MODIFY: mod_mem[wr_addr]  <= wr_data;
        CLS_LENGTH: len_mem[wr_addr]  <= wr_data;
        CLS_BASE:   base_mem[wr_addr] <= wr_data;
        default: ;
      endcase
    end
  end

  assign rd_idx  = idx_mem[rd_ptr_addr];
  assign rd_base = base_mem[rd_ptr_addr];
  assign rd_len  = len_mem[rd_ptr_addr];
  assign rd_mod  = mod_mem[rd_mod_addr];

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_class == CLS_INDEX && upd_en && upd_addr == wr_addr)
    |=> idx_mem[$past(wr_addr)] == $past(wr_data)); // R9
endmodule

// File: rtl/cbuf_wrap.sv
module cbuf_wrap #(
  parameter int W = 32,
  localparam int XW = W + 2
) (
  input  logic [W-1:0] idx,
  input  logic [W-1:0] mod,
  input  logic [W-1:0] base,
  input  logic [W-1:0] len,
  output logic [W-1:0] nxt
);
  logic signed [XW-1:0] sum, top, lo, len_x;
  logic signed [XW-1:0] res;

  always_comb begin
    sum   = $signed({2'b00, idx}) + $signed({{2{mod[W-1]}}, mod});
    lo    = $signed({2'b00, base});
    len_x = $signed({2'b00, len});
    top   = lo + len_x;
    res   = sum;
    if (len != '0) begin
      if (sum >= top)     res = sum - len_x;
      else if (sum < lo)  res = sum + len_x;
    end
    nxt = res[W-1:0];
  end
endmodule

// File: rtl/cbuf_bitrev.sv
module cbuf_bitrev #(
  parameter int W = 32,
  localparam int NBW = $clog2(W + 1)
) (
  input  logic [W-1:0]   din,
  input  logic [NBW-1:0] nbits,
  output logic [W-1:0]   dout
);
  logic [W-1:0] mirrored, mask, shifted;
  logic [NBW:0] shamt;

  for (genvar g = 0; g < W; g++) begin : g_lane
    assign mirrored[g] = din[W-1-g];
    assign mask[g]     = (NBW'(g) < nbits);
  end

  always_comb begin
    shamt   = (nbits >= NBW'(W)) ? '0 : (NBW+1)'(W) - {1'b0, nbits};
    shifted = mirrored >> shamt;
    dout    = (din & ~mask) | (shifted & mask);
  end
endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen
  import cbuf_agen_pkg::*;
#(
  parameter int W     = 32,
  parameter int NSETS = 16,
  localparam int SW   = $clog2(NSETS),
  localparam int DAW  = SW + 1,
  localparam int NBW  = $clog2(W + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bank_sel,
  input  logic           wr_en,
  input  logic [1:0]     wr_class,
  input  logic [SW-1:0]  wr_slot,
  input  logic [W-1:0]   wr_data,
  input  logic           acc_valid,
  input  logic [SW-1:0]  acc_ptr,
  input  logic [SW-1:0]  acc_mod,
  input  logic           brev_en,
  input  logic [NBW-1:0] brev_n,
  output logic           addr_valid,
  output logic [W-1:0]   addr
);
  logic [W-1:0] cur_idx, cur_base, cur_len, cur_mod, nxt_idx, rev_idx;
  logic [W-1:0] addr_q;
  logic         valid_q;

  cbuf_regbank #(.W(W), .DEPTH(2 * NSETS)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_class    (reg_class_e'(wr_class)),
    .wr_addr     ({bank_sel, wr_slot}),
    .wr_data     (wr_data),
    .upd_en      (acc_valid),
    .upd_addr    ({bank_sel, acc_ptr}),
    .upd_data    (nxt_idx),
    .rd_ptr_addr ({bank_sel, acc_ptr}),
    .rd_mod_addr ({bank_sel, acc_mod}),
    .rd_idx      (cur_idx),
    .rd_base     (cur_base),
    .rd_len      (cur_len),
    .rd_mod      (cur_mod)
  );

  cbuf_wrap #(.W(W)) u_wrap (
    .idx  (cur_idx),
    .mod  (cur_mod),
    .base (cur_base),
    .len  (cur_len),
    .nxt  (nxt_idx)
  );

  cbuf_bitrev #(.W(W)) u_rev (
    .din   (cur_idx),
    .nbits (brev_n),
    .dout  (rev_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= acc_valid;
      if (acc_valid) addr_q <= brev_en ? rev_idx : cur_idx;
    end
  end

  assign addr_valid = valid_q;
  assign addr       = addr_q;

  // Checks on the interplay of the register bank, wrap and mirror units
  logic [W-1:0] mod_mag;
  logic [W:0]   win_top;
  logic         old_in, new_in;
  assign mod_mag = cur_mod[W-1] ? (~cur_mod + 1'b1) : cur_mod;
  assign win_top = {1'b0, cur_base} + {1'b0, cur_len};
  assign old_in  = (cur_idx >= cur_base) && ({1'b0, cur_idx} < win_top);
  assign new_in  = (nxt_idx >= cur_base) && ({1'b0, nxt_idx} < win_top);

  AST_STAY_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && cur_len != '0 && old_in && mod_mag <= cur_len) |-> new_in); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && cur_len == '0) |-> nxt_idx == cur_idx + cur_mod); // R5

  AST_MIRROR_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && brev_n < NBW'(W)) |-> (rev_idx >> brev_n) == (cur_idx >> brev_n)); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> $stable(addr)); // R10
endmodule

// File: tb/cbuf_agen_test.sv
module cbuf_agen_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_sel = 1'b0, wr_en = 1'b0, acc_valid = 1'b0, brev_en = 1'b0;
  logic [1:0]  wr_class = 2'd0;
  logic [3:0]  wr_slot = '0, acc_ptr = '0, acc_mod = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  brev_n = '0;
  logic        addr_valid;
  logic [31:0] addr;

  always #(CLK_P/2) clk = ~clk;

  cbuf_agen uut (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .wr_en(wr_en), .wr_class(wr_class),
    .wr_slot(wr_slot), .wr_data(wr_data), .acc_valid(acc_valid), .acc_ptr(acc_ptr),
    .acc_mod(acc_mod), .brev_en(brev_en), .brev_n(brev_n),
    .addr_valid(addr_valid), .addr(addr)
  );

  // Behavioural reference state
  logic [31:0] m_idx [32], m_mod [32], m_len [32], m_base [32];
  logic [31:0] exp_addr = '0;
  logic        exp_valid = 1'b0;
  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  function automatic logic [31:0] ref_next(logic [31:0] i, logic [31:0] m,
                                           logic [31:0] b, logic [31:0] l);
    longint s = longint'(i) + longint'($signed(m));
    if (l != 0) begin
      if (s >= longint'(b) + longint'(l)) s -= longint'(l);
      else if (s < longint'(b))           s += longint'(l);
    end
    return s[31:0];
  endfunction

  function automatic logic [31:0] ref_rev(logic [31:0] v, int n);
    logic [31:0] r = v;
    if (n > 32) n = 32;
    for (int k = 0; k < n; k++) r[k] = v[n-1-k];
    return r;
  endfunction

  task automatic check(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step();
    int p, q, w;
    @(posedge clk);
    if (rst) begin
      for (int k = 0; k < 32; k++) begin
        m_idx[k] = '0; m_mod[k] = '0; m_len[k] = '0; m_base[k] = '0;
      end
      exp_valid = 1'b0;
      exp_addr  = '0;
    end else begin
      p = int'(bank_sel) * 16 + int'(acc_ptr);
      q = int'(bank_sel) * 16 + int'(acc_mod);
      w = int'(bank_sel) * 16 + int'(wr_slot);
      exp_valid = acc_valid;
      if (acc_valid) begin
        exp_addr = brev_en ? ref_rev(m_idx[p], int'(brev_n)) : m_idx[p];
        m_idx[p] = ref_next(m_idx[p], m_mod[q], m_base[p], m_len[p]);
      end
      if (wr_en) begin
        case (wr_class)
          2'd0: m_idx[w]  = wr_data;
          2'd1: m_mod[w]  = wr_data;
          2'd2: m_len[w]  = wr_data;
          default: m_base[w] = wr_data;
        endcase
      end
    end
    @(negedge clk);
    check("addr_valid", {31'b0, addr_valid}, {31'b0, exp_valid});
    check("addr", addr, exp_addr);
  endtask

  task automatic wr(int cls, int slot, logic [31:0] d);
    wr_en = 1'b1; wr_class = 2'(cls); wr_slot = 4'(slot); wr_data = d; acc_valid = 1'b0;
    step();
    wr_en = 1'b0;
  endtask

  task automatic acc(int ptr, int md);
    acc_valid = 1'b1; acc_ptr = 4'(ptr); acc_mod = 4'(md);
    step();
    acc_valid = 1'b0;
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in %s", tag);
      report();
    end
  end

  initial begin
    // R1: reset state, registers cleared
    tag = "R1";
    repeat (3) step();
    rst = 1'b0;
    @(negedge clk);
    acc(0, 0);
    acc(0, 0);

    // R8 / R3: window [100,110), index 105, step +3
    tag = "R8";
    wr(3, 2, 32'd100); wr(2, 2, 32'd10); wr(0, 2, 32'd105); wr(1, 1, 32'd3);
    tag = "R3";
    for (int k = 0; k < 6; k++) acc(2, 1);   // 105,108,101,104,107,100

    // R4: negative modifier wraps upward
    tag = "R4";
    wr(1, 3, 32'hFFFF_FFFC);
    for (int k = 0; k < 5; k++) acc(2, 3);

    // R5: zero length is linear, modulo 2^32
    tag = "R5";
    wr(0, 5, 32'hFFFF_FFFE); wr(1, 4, 32'd3);
    acc(5, 4); acc(5, 4); acc(5, 4);

    // R6: mirror low bits over a window of 8
    tag = "R6";
    wr(3, 6, 32'h1000); wr(2, 6, 32'd8); wr(0, 6, 32'h1000); wr(1, 7, 32'd1);
    brev_en = 1'b1; brev_n = 6'd3;
    for (int k = 0; k < 9; k++) acc(6, 7);
    brev_n = 6'd0;  acc(6, 7);
    brev_n = 6'd32; acc(6, 7);
    brev_n = 6'd12; acc(6, 7);
    brev_en = 1'b0;

    // R7: secondary bank independent of primary
    tag = "R7";
    bank_sel = 1'b1;
    wr(0, 2, 32'd500); wr(1, 1, 32'd7);
    acc(2, 1); acc(2, 1);
    bank_sel = 1'b0;
    acc(2, 1);
    bank_sel = 1'b1;
    acc(2, 1);
    bank_sel = 1'b0;

    // R9: write and post-modify on the same index in one cycle
    tag = "R9";
    wr_en = 1'b1; wr_class = 2'd0; wr_slot = 4'd2; wr_data = 32'd103;
    acc(2, 1);
    wr_en = 1'b0;
    acc(2, 1);

    // R10: address held while idle
    tag = "R10";
    repeat (4) step();

    // Mixed random traffic against the model (R2, R3, R9)
    tag = "R2";
    for (int n = 0; n < 400; n++) begin
      int c = $urandom_range(0, 3);
      bank_sel  = 1'($urandom_range(0, 1));
      wr_en     = 1'($urandom_range(0, 2) == 0);
      wr_class  = 2'(c);
      wr_slot   = 4'($urandom_range(0, 15));
      case (c)
        0, 3:    wr_data = 32'($urandom_range(0, 1200));
        2:       wr_data = 32'($urandom_range(0, 20));
        default: wr_data = 32'($signed($urandom_range(0, 40)) - 20);
      endcase
      acc_valid = 1'($urandom_range(0, 2) != 0);
      acc_ptr   = 4'($urandom_range(0, 15));
      acc_mod   = 4'($urandom_range(0, 15));
      brev_en   = 1'($urandom_range(0, 3) == 0);
      brev_n    = 6'($urandom_range(0, 32));
      step();
    end
    wr_en = 1'b0; acc_valid = 1'b0; brev_en = 1'b0;
    step();

    // R1 again: reset mid-run clears everything
    tag = "R1";
    rst = 1'b1; step(); rst = 1'b0;
    bank_sel = 1'b1; acc(2, 1);
    bank_sel = 1'b0; acc(2, 1);

    done = 1;
    report();
  end
endmodule